// File: doc/BRIEF.md
# Dual-Enable Switch Sequencer with Fault Flag

This block decides when a protected power switch may turn on. Two enable inputs form the switch request. One is an active-low high-voltage enable and the other an active-high logic enable. Both are synchronised to the block clock. The request becomes a turn-on command only while the supply sits between its undervoltage and overvoltage limits. A power-on debounce measured in ticks of a slow timebase comes first. The debounce is skipped when the output rail is already above its own undervoltage level.

The block also handles thermal shutdown. The switch is dropped at once, and the recovery path follows the current-limit mode code: a retry wait, a debounce, or a latch that only an enable toggle or a supply cycle releases. A one-clock clear pulse marks every off-to-on change of the synchronised request. An active-low fault flag, registered once, gathers the fault sources.

Top module: `pwr_enable_ctl`

## Requirements
- R1: The request is off only when `hv_en_ni`=1 and `en_i`=0. The other three combinations request on. Both enables pass two synchroniser flops, so a change seen at the inputs reaches `sw_on_o` at the third rising edge when no debounce applies.
- R2: With `out_ok_i`=0, a qualifying event (supply entering its window, or the request turning on) starts a debounce. `sw_on_o` rises on the edge that takes the DEB_TICKS-th tick. Clocks without `tick_i` do not advance the debounce.
- R3: If `uv_in_i` or `ov_in_i` rises during the debounce, the switch stays off and the next qualifying event restarts the full count.
- R4: If `out_ok_i`=1 when the switch is allowed (enable, or leaving overvoltage), `sw_on_o` rises on the next edge with no debounce.
- R5: `clr_o` is a single-clock pulse on each off-to-on change of the synchronised request, and it releases a thermal latch.
- R6: `flag_no` is low one edge after any of `drop_i`, `rev_i`, `tsd_i`, `iset_short_i`, `uv_in_i` or `ov_in_i` is high. It is high out of reset and when no source is present.
- R7: `tsd_i` high while on turns the switch off at the next edge. `flag_no` stays low while the thermal recovery is pending.
- R8: Mode `mode_i`=2'b01 (autoretry): after `tsd_i` falls, the switch returns on the edge that takes the RETRY_TICKS-th tick.
- R9: Mode `mode_i`=2'b10 or 2'b11 (continuous): after `tsd_i` falls, a full debounce is applied, whatever `out_ok_i` says.
- R10: Mode `mode_i`=2'b00 (latchoff): after a thermal trip the switch stays off until `clr_o` or `uv_in_i` high. It then turns on again through the normal start path.
- R11: `iset_short_i` high prevents turn-on from off or debounce. It does not turn off a switch that is already on.
- R12: The request going off, or `uv_in_i` or `ov_in_i` rising, turns a running switch off at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hv_en_ni | input | 1 | High-voltage enable, active low |
| en_i | input | 1 | Logic enable, active high |
| uv_in_i | input | 1 | Supply below undervoltage level |
| ov_in_i | input | 1 | Supply above overvoltage level |
| out_ok_i | input | 1 | Output rail above its undervoltage level |
| tsd_i | input | 1 | Thermal shutdown comparator (hysteresis external) |
| iset_short_i | input | 1 | Current-set pin shorted to ground |
| drop_i | input | 1 | Switch drop above flag threshold |
| rev_i | input | 1 | Reverse-current fault tripped |
| mode_i | input | 2 | Current-limit mode: 00 latchoff, 01 autoretry, 1x continuous |
| tick_i | input | 1 | Timebase tick for debounce and retry counts |
| sw_on_o | output | 1 | Switch turn-on command |
| flag_no | output | 1 | Fault flag, active low |
| clr_o | output | 1 | Fault-clear pulse |

## Verification
A wrong sequencer state shows as `sw_on_o` rising too early or too late. A counter error moves the turn-on edge by whole ticks, and the bench measures that edge exactly against DEB_TICKS or RETRY_TICKS from the stimulus. A state that should have latched but did not shows as the switch coming back within tens of cycles instead of staying off. A wrong flag aggregation shows one edge after a single fault source is raised. The bench sweeps all four enable pairs, all four mode codes and each flag source on its own.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DEB,
    ST_ON,
    ST_HOT,
    ST_RETRY,
    ST_LATCH
  } seq_state_e;

  typedef enum logic [1:0] {
    RC_LATCH,
    RC_RETRY,
    RC_CONT
  } recov_e;

  // 00 latchoff, 01 autoretry, 1x continuous
  function automatic recov_e decode_mode(logic [1:0] code);
    if (code[1]) return RC_CONT;
    else if (code[0]) return RC_RETRY;
    else return RC_LATCH;
  endfunction

endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pec_req.sv
module pec_req #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hv_en_ni,
  input  logic en_i,
  output logic req_o,
  output logic clr_o
);
  logic hv_s, en_s, req_prev_q;

  // reset values decode as "off" so the first enable is a clean off->on
  pec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hv_en_ni), .q_o(hv_s));
  pec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s));

  assign req_o = !(hv_s && !en_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_prev_q <= 1'b0;
    else         req_prev_q <= req_o;
  end

  assign clr_o = req_o && !req_prev_q;

  a_r5_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);
  a_r5_clr_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> req_prev_q);
endmodule

// File: rtl/pec_flag.sv
module pec_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic rev_i,
  input  logic tsd_i,
  input  logic hot_i,
  input  logic iset_short_i,
  input  logic uv_i,
  input  logic ov_i,
  output logic flag_no
);
  logic any_fault;
  logic flag_q;

  assign any_fault = drop_i | rev_i | tsd_i | hot_i | iset_short_i | uv_i | ov_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b1;
    else         flag_q <= !any_fault;
  end

  assign flag_no = flag_q;

  a_r6_flag_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i || rev_i || iset_short_i || uv_i || ov_i) |=> !flag_no);
  a_r7_hot_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |=> !flag_no);
endmodule

// File: rtl/pec_seq.sv
module pec_seq
  import pec_pkg::*;
#(
  parameter int unsigned DEB_TICKS   = 12,
  parameter int unsigned RETRY_TICKS = 7200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       clr_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       out_ok_i,
  input  logic       tsd_i,
  input  logic       iset_short_i,
  input  logic [1:0] mode_i,
  input  logic       tick_i,
  output logic       sw_on_o,
  output logic       hot_o
);
  localparam int unsigned CNT_MAX = (DEB_TICKS > RETRY_TICKS) ? DEB_TICKS : RETRY_TICKS;
  localparam int unsigned CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CW-1:0] DEB_LAST   = CW'(DEB_TICKS - 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          retry_q, retry_d;
  logic          permit;
  recov_e        rc;

  assign permit = req_i && !uv_i && !ov_i;
  assign rc     = decode_mode(mode_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    retry_d = retry_q;
    unique case (state_q)
      ST_OFF: begin
        if (permit && !iset_short_i) begin
          cnt_d = '0;
          state_d = out_ok_i ? ST_ON : ST_DEB;
        end
      end
      ST_DEB: begin
        if (!permit || iset_short_i) state_d = ST_OFF;
        else if (tick_i) begin
          if (cnt_q == DEB_LAST) state_d = ST_ON;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ON: begin
        if (!permit) state_d = ST_OFF;
        else if (tsd_i) begin
          retry_d = (rc == RC_RETRY);
          state_d = (rc == RC_LATCH) ? ST_LATCH : ST_HOT;
        end
      end
      ST_HOT: begin
        if (!permit) state_d = ST_OFF;
        else if (!tsd_i) begin
          cnt_d   = '0;
          state_d = retry_q ? ST_RETRY : ST_DEB;
        end
      end
      ST_RETRY: begin
        if (!permit) state_d = ST_OFF;
        else if (tick_i) begin
          if (cnt_q == RETRY_LAST) state_d = ST_ON;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LATCH: begin
        if (clr_i || uv_i) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      retry_q <= retry_d;
    end
  end

  assign sw_on_o = (state_q == ST_ON);
  assign hot_o   = (state_q == ST_HOT) || (state_q == ST_RETRY) || (state_q == ST_LATCH);

  a_r12_on_needs_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_o |-> $past(permit));
  a_r7_hot_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_on_o && tsd_i) |=> !sw_on_o);
  a_r10_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && !clr_i && !uv_i) |=> (state_q == ST_LATCH));
  a_r11_iset_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_on_o && iset_short_i && (state_q == ST_OFF || state_q == ST_DEB)) |=> !sw_on_o);
  a_r2_deb_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEB) |-> (cnt_q <= DEB_LAST));
  a_r8_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETRY) |-> (cnt_q <= RETRY_LAST));
endmodule

// File: rtl/pwr_enable_ctl.sv
module pwr_enable_ctl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_TICKS   = 12,
  parameter int unsigned RETRY_TICKS = 7200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hv_en_ni,
  input  logic       en_i,
  input  logic       uv_in_i,
  input  logic       ov_in_i,
  input  logic       out_ok_i,
  input  logic       tsd_i,
  input  logic       iset_short_i,
  input  logic       drop_i,
  input  logic       rev_i,
  input  logic [1:0] mode_i,
  input  logic       tick_i,
  output logic       sw_on_o,
  output logic       flag_no,
  output logic       clr_o
);
  logic req, clr, hot;

  pec_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .hv_en_ni(hv_en_ni), .en_i(en_i),
    .req_o(req), .clr_o(clr));

  pec_seq #(.DEB_TICKS(DEB_TICKS), .RETRY_TICKS(RETRY_TICKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .clr_i(clr),
    .uv_i(uv_in_i), .ov_i(ov_in_i), .out_ok_i(out_ok_i), .tsd_i(tsd_i),
    .iset_short_i(iset_short_i), .mode_i(mode_i), .tick_i(tick_i),
    .sw_on_o(sw_on_o), .hot_o(hot));

  pec_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .drop_i(drop_i), .rev_i(rev_i),
    .tsd_i(tsd_i), .hot_i(hot), .iset_short_i(iset_short_i),
    .uv_i(uv_in_i), .ov_i(ov_in_i), .flag_no(flag_no));

  assign clr_o = clr;
endmodule

// File: tb/pwr_enable_ctl_tb.sv
module pwr_enable_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB   = 4;
  localparam int RETRY = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv_en_n = 1'b1, en = 1'b0, uv = 1'b0, ov = 1'b0, out_ok = 1'b0;
  logic tsd = 1'b0, iset = 1'b0, drop = 1'b0, rev = 1'b0, tick = 1'b1;
  logic [1:0] mode = 2'b10;
  logic sw_on, flag_n, clr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_enable_ctl #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .RETRY_TICKS(RETRY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hv_en_ni(hv_en_n), .en_i(en),
    .uv_in_i(uv), .ov_in_i(ov), .out_ok_i(out_ok), .tsd_i(tsd),
    .iset_short_i(iset), .drop_i(drop), .rev_i(rev), .mode_i(mode),
    .tick_i(tick), .sw_on_o(sw_on), .flag_no(flag_n), .clr_o(clr));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // edges until sw_on is seen high; returns limit if never
  task automatic measure(int limit, output int n);
    n = 0;
    while (!sw_on && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic go_off();
    hv_en_n = 1'b1; en = 1'b0;
    step(4);
  endtask

  task automatic bring_on();
    int n;
    out_ok = 1'b1; hv_en_n = 1'b0; en = 1'b1;
    measure(20, n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    step();
    check("R6 reset flag", flag_n, 1);
    check("R1 reset sw_on", sw_on, 0);
    check("R5 reset clr", clr, 0);

    // R1/R4/R5: all enable pairs, output already up
    out_ok = 1'b1;
    for (int p = 0; p < 4; p++) begin
      int first, pulses;
      go_off();
      hv_en_n = p[1]; en = p[0];
      first = -1; pulses = 0;
      for (int k = 1; k <= 8; k++) begin
        step();
        if (sw_on && first < 0) first = k;
        if (clr) pulses++;
      end
      check("R1 enable pair latency", first, (p == 2) ? -1 : 3);
      check("R5 clr pulse count", pulses, (p == 2) ? 0 : 1);
    end

    // R2: debounce after enable with output low
    go_off();
    out_ok = 1'b0; hv_en_n = 1'b0; en = 1'b1;
    measure(40, n);
    check("R2 enable debounce", n, 3 + DEB);
    // R12: undervoltage drops running switch in one edge
    uv = 1'b1; step();
    check("R12 uv turns off", sw_on, 0);
    step();
    uv = 1'b0;
    measure(40, n);
    check("R2 supply debounce", n, DEB + 1);

    // R3: undervoltage and overvoltage during debounce restart the count
    uv = 1'b1; step(2); uv = 1'b0; step(DEB - 1);
    uv = 1'b1; step();
    check("R3 uv in debounce", sw_on, 0);
    uv = 1'b0;
    measure(40, n);
    check("R3 restart after uv", n, DEB + 1);
    ov = 1'b1; step(2); ov = 1'b0; step(DEB - 1);
    ov = 1'b1; step();
    check("R3 ov in debounce", sw_on, 0);
    ov = 1'b0;
    measure(40, n);
    check("R3 restart after ov", n, DEB + 1);

    // R2: no tick, no progress
    uv = 1'b1; step(2); tick = 1'b0; uv = 1'b0; step(30);
    check("R2 no tick holds off", sw_on, 0);
    tick = 1'b1;
    measure(40, n);
    check("R2 resume ticks", n, DEB);

    // R4: leaving overvoltage with output up
    out_ok = 1'b1;
    ov = 1'b1; step(2);
    check("R12 ov turns off", sw_on, 0);
    ov = 1'b0;
    measure(40, n);
    check("R4 ov exit no debounce", n, 1);

    // R6: each non-thermal source alone
    for (int s = 0; s < 5; s++) begin
      bring_on();
      drop = (s == 0); rev = (s == 1); iset = (s == 2); uv = (s == 3); ov = (s == 4);
      step();
      check($sformatf("R6 flag source %0d", s), flag_n, 0);
      drop = 0; rev = 0; iset = 0; uv = 0; ov = 0;
      step();
      check($sformatf("R6 flag release %0d", s), flag_n, 1);
    end

    // R7/R8/R9/R10: thermal recovery per mode code
    for (int m = 0; m < 4; m++) begin
      bring_on();
      mode = m[1:0];
      out_ok = 1'b0;
      tsd = 1'b1; step();
      check("R7 thermal off", sw_on, 0);
      step(5);
      check("R7 flag during thermal", flag_n, 0);
      tsd = 1'b0;
      measure(60, n);
      if (m == 0) begin
        check("R10 latch holds", n, 60);
        check("R10 latch flag", flag_n, 0);
        out_ok = 1'b1;
        uv = 1'b1; step(); uv = 1'b0;
        measure(20, n);
        check("R10 power cycle release", n, 1);
      end else if (m == 1) begin
        check("R8 retry delay", n, RETRY + 1);
      end else begin
        check("R9 continuous debounce", n, DEB + 1);
      end
    end

    // R10/R5: latch released by enable toggle
    mode = 2'b00; out_ok = 1'b1;
    bring_on();
    tsd = 1'b1; step(); tsd = 1'b0; step(20);
    check("R10 latch before toggle", sw_on, 0);
    go_off();
    check("R10 latch with enable off", sw_on, 0);
    en = 1'b1;
    begin
      int first, pulses;
      first = -1; pulses = 0;
      for (int k = 1; k <= 8; k++) begin
        step();
        if (sw_on && first < 0) first = k;
        if (clr) pulses++;
      end
      check("R10 toggle releases latch", first, 4);
      check("R5 toggle clr pulse", pulses, 1);
    end

    // R11: shorted set pin
    iset = 1'b1; step(5);
    check("R11 running switch kept", sw_on, 1);
    uv = 1'b1; step(); uv = 1'b0; step(20);
    check("R11 start blocked", sw_on, 0);
    out_ok = 1'b0; iset = 1'b0; step(2); iset = 1'b1; step(DEB + 3);
    check("R11 blocked in debounce", sw_on, 0);
    out_ok = 1'b1; iset = 1'b0;
    measure(20, n);
    check("R11 release start", n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule